// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits behind a clock and data recovery stage. It receives the recovered serial bit stream on the bit clock and looks for the SDH/SONET framing pattern. That pattern is a run of A1 bytes followed by a run of A2 bytes. When it finds the pattern, it restarts its divide-by-8 byte clock so that the byte following the last A2 lands whole on the 8-bit parallel bus. On that byte it raises a frame pulse for one byte-clock period.

The search does not run all the time. A downstream framing processor drives an out-of-frame input, and a rising edge on that input arms the search. The search is disarmed only when two conditions both hold, in either order: a frame pulse has been issued, and the out-of-frame input is low. While the search is disarmed, the block keeps its current byte phase, and framing patterns on the line are ignored. A signal-detect input forces the parallel bus to zero whenever the line signal is lost.

Top module: `sonet_byte_aligner`

## Requirements
- R1: While `rst_n` is low at a bit-clock edge, the block clears its state. From the next edge, `par_data` is 0, `frame_pulse` is 0 and `byte_clk` is 1.
- R2: A rising edge on `oof` arms the search. With `oof` held low since reset, a full framing pattern produces no frame pulse.
- R3: While armed, the block detects the serial sequence F6 F6 F6 28 28 28 (hex, most significant bit first). The 8 bits that follow the last 28 then appear as one byte on `par_data`, bit 7 being the first received. This byte appears in the bit cycle after its last bit is sampled.
- R4: `frame_pulse` rises together with the first aligned byte and with a rising edge of `byte_clk`. It stays high for exactly 8 bit-clock cycles.
- R5: With `oof` still high after a frame pulse, the search stays armed, and a framing pattern at a new bit phase realigns the bus. Once `oof` is low after a frame pulse, the search is disarmed.
- R6: If `oof` falls before any frame pulse, the search stays armed. The next frame pulse then disarms it.
- R7: While `sig_det` is 0, `par_data` is 0. When `sig_det` returns to 1, the bus shows the byte collected at the retained phase.
- R8: While disarmed, a framing pattern at a shifted phase produces no frame pulse, and bytes keep the previous phase.
- R9: `byte_clk` is the bit clock divided by 8: 4 cycles high, then 4 cycles low. `par_data` changes only on a rising edge of `byte_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Recovered serial data, sampled on the rising edge of clk_bit |
| oof | input | 1 | Out-of-frame request; a rising edge arms the search |
| sig_det | input | 1 | Signal present (1) or lost (0) |
| byte_clk | output | 1 | Byte clock, clk_bit divided by 8 |
| par_data | output | 8 | Aligned parallel byte, squelched to zero on loss of signal |
| frame_pulse | output | 1 | High for one byte period on the first aligned byte |

## Verification
The assertions take `oof`, `sig_det` and `ser_in` to be synchronous to the bit clock. The stability property on `par_data` is exempt from the cycles around a change of `sig_det`, because the squelch acts at once and not on a byte edge. The bench changes every input only on the falling edge of `clk_bit`. It sends framing patterns only at phases it chooses, and it follows each pattern with data bytes that cannot re-form the pattern, so no unintended second match occurs.

// File: rtl/sba_pkg.sv
package sba_pkg;
   localparam int          SBA_BYTE_W = 8;
   localparam logic [7:0]  SBA_A1     = 8'hF6;
   localparam logic [7:0]  SBA_A2     = 8'h28;
   localparam int          SBA_N_A1   = 3;
   localparam int          SBA_N_A2   = 3;
endpackage

// File: rtl/sba_shift.sv
module sba_shift #(
   parameter int WIN_W = 48
) (
   input  logic             clk_bit,
   input  logic             rst_n,
   input  logic             ser_in,
   output logic [WIN_W-1:0] window
);
   always_ff @(posedge clk_bit) begin
      if (!rst_n) window <= '0;
      else        window <= {window[WIN_W-2:0], ser_in};
   end
endmodule

// File: rtl/sba_match.sv
module sba_match #(
   parameter int                BYTE_W = 8,
   parameter int                N_A1   = 3,
   parameter int                N_A2   = 3,
   parameter logic [BYTE_W-1:0] A1     = 8'hF6,
   parameter logic [BYTE_W-1:0] A2     = 8'h28
) (
   input  logic [BYTE_W*(N_A1+N_A2)-1:0] window,
   input  logic                          armed,
   output logic                          hit
);
   localparam int N_BYTES = N_A1 + N_A2;
   localparam int WIN_W   = BYTE_W * N_BYTES;

   logic [N_BYTES-1:0] byte_hit;

   for (genvar g = 0; g < N_BYTES; g++) begin : g_cmp
      localparam logic [BYTE_W-1:0] EXP = (g < N_A1) ? A1 : A2;
      assign byte_hit[g] = (window[WIN_W-1-g*BYTE_W -: BYTE_W] == EXP);
   end

   assign hit = armed & (&byte_hit);
endmodule

// File: rtl/sba_framer.sv
module sba_framer #(
   parameter int BYTE_W = 8
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic [BYTE_W-2:0] win_lo,
   input  logic              hit,
   output logic [BYTE_W-1:0] byte_q,
   output logic              fp_q,
   output logic              byte_clk,
   output logic              fp_issue,
   output logic              pending
);
   localparam int            CW   = $clog2(BYTE_W);
   localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt;
   logic          load;

   assign load     = (cnt == LAST);
   assign fp_issue = load & pending;
   assign byte_clk = ~cnt[CW-1];

   always_ff @(posedge clk_bit) begin
      if (!rst_n) begin
         cnt     <= '0;
         byte_q  <= '0;
         fp_q    <= 1'b0;
         pending <= 1'b0;
      end else begin
         // a match restarts the byte phase: the next bit is bit 0 of a byte
         if (hit) cnt <= ONE;
         else     cnt <= cnt + ONE;
         if (load) begin
            byte_q <= {win_lo, ser_in};
            fp_q   <= pending;
         end
         if (hit)       pending <= 1'b1;
         else if (load) pending <= 1'b0;
      end
   end
endmodule

// File: rtl/sba_arm.sv
module sba_arm (
   input  logic clk_bit,
   input  logic rst_n,
   input  logic oof,
   input  logic fp_issue,
   input  logic pending,
   output logic armed
);
   logic oof_d;
   logic fp_done;

   always_ff @(posedge clk_bit) begin
      if (!rst_n) begin
         oof_d   <= 1'b0;
         armed   <= 1'b0;
         fp_done <= 1'b0;
      end else begin
         oof_d <= oof;
         if (oof && !oof_d) begin
            armed   <= 1'b1;
            fp_done <= 1'b0;
         end else begin
            if (fp_issue) fp_done <= 1'b1;
            // both conditions, in either order, and no pulse still owed
            if (armed && fp_done && !pending && !oof) armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner #(
   parameter int                BYTE_W     = sba_pkg::SBA_BYTE_W,
   parameter int                N_A1       = sba_pkg::SBA_N_A1,
   parameter int                N_A2       = sba_pkg::SBA_N_A2,
   parameter logic [BYTE_W-1:0] A1         = BYTE_W'(sba_pkg::SBA_A1),
   parameter logic [BYTE_W-1:0] A2         = BYTE_W'(sba_pkg::SBA_A2),
   parameter bit                SQUELCH_EN = 1'b1
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              oof,
   input  logic              sig_det,
   output logic              byte_clk,
   output logic [BYTE_W-1:0] par_data,
   output logic              frame_pulse
);
   localparam int WIN_W = BYTE_W * (N_A1 + N_A2);

   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_w
      $error("BYTE_W must be a power of two, at least 2");
   end
   if (N_A1 < 1 || N_A2 < 1) begin : g_bad_n
      $error("N_A1 and N_A2 must each be at least 1");
   end

   logic [WIN_W-1:0]  window;
   logic              hit;
   logic              armed;
   logic              fp_issue;
   logic              pending;
   logic [BYTE_W-1:0] byte_q;

   sba_shift #(.WIN_W(WIN_W)) u_shift (
      .clk_bit(clk_bit), .rst_n(rst_n), .ser_in(ser_in), .window(window)
   );

   sba_match #(.BYTE_W(BYTE_W), .N_A1(N_A1), .N_A2(N_A2), .A1(A1), .A2(A2)) u_match (
      .window(window), .armed(armed), .hit(hit)
   );

   sba_framer #(.BYTE_W(BYTE_W)) u_framer (
      .clk_bit(clk_bit), .rst_n(rst_n), .ser_in(ser_in),
      .win_lo(window[BYTE_W-2:0]), .hit(hit),
      .byte_q(byte_q), .fp_q(frame_pulse), .byte_clk(byte_clk),
      .fp_issue(fp_issue), .pending(pending)
   );

   sba_arm u_arm (
      .clk_bit(clk_bit), .rst_n(rst_n), .oof(oof),
      .fp_issue(fp_issue), .pending(pending), .armed(armed)
   );

   if (SQUELCH_EN) begin : g_squelch
      assign par_data = sig_det ? byte_q : '0;
   end else begin : g_pass
      logic unused_sd;
      assign unused_sd = sig_det;
      assign par_data  = byte_q;
   end
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
   parameter int BYTE_W = 8
) (
   input logic              clk_bit,
   input logic              rst_n,
   input logic              oof,
   input logic              sig_det,
   input logic              byte_clk,
   input logic [BYTE_W-1:0] par_data,
   input logic              frame_pulse,
   input logic              armed
);
   localparam int            RW   = $clog2(BYTE_W) + 2;
   localparam logic [RW-1:0] RMAX = '1;

   logic [RW-1:0] fp_run;

   always_ff @(posedge clk_bit) begin
      if (!rst_n)                           fp_run <= '0;
      else if (!frame_pulse)                fp_run <= '0;
      else if (fp_run != RMAX)              fp_run <= fp_run + RW'(1);
   end

   // R1
   a_r1_reset_clears: assert property (@(posedge clk_bit)
      !rst_n |=> (!frame_pulse && par_data == '0));

   // R2
   a_r2_arm_on_rise: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $rose(oof) |=> armed);

   // R4
   a_r4_fp_len: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $fell(frame_pulse) |-> (fp_run == RW'(BYTE_W)));

   // R4
   a_r4_fp_on_byteclk: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $rose(frame_pulse) |-> $rose(byte_clk));

   // R5
   a_r5_disarm_oof_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $fell(armed) |-> !$past(oof));

   // R8
   a_r8_fp_needs_arm: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $rose(frame_pulse) |-> $past(armed));

   // R9
   a_r9_data_steady: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (sig_det && $past(sig_det) && !$rose(byte_clk)) |-> $stable(par_data));
endmodule

bind sonet_byte_aligner sba_checker #(.BYTE_W(BYTE_W)) u_sba_checker (
   .clk_bit(clk_bit), .rst_n(rst_n), .oof(oof), .sig_det(sig_det),
   .byte_clk(byte_clk), .par_data(par_data), .frame_pulse(frame_pulse),
   .armed(armed)
);

// File: tb/sonet_byte_aligner_bench.sv
`timescale 1ns/1ps
module sonet_byte_aligner_bench;
   localparam logic [47:0] PAT = 48'hF6F6F6282828;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       oof = 1'b0;
   logic       sig_det = 1'b1;
   logic       byte_clk;
   logic [7:0] par_data;
   logic       fp;
   int         tests = 0;
   int         fails = 0;

   always #5 clk = ~clk;

   sonet_byte_aligner u_sonet_byte_aligner (
      .clk_bit(clk), .rst_n(rst_n), .ser_in(ser_in), .oof(oof),
      .sig_det(sig_det), .byte_clk(byte_clk), .par_data(par_data),
      .frame_pulse(fp)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // starts and ends on a falling edge; one bit per bit-clock cycle
   task automatic send_vec(input logic [63:0] v, input int n, input bit watch, input string req);
      int seen = 0;
      for (int i = n - 1; i >= 0; i--) begin
         ser_in = v[i];
         @(negedge clk);
         if (fp) seen++;
      end
      if (watch) chk(req, 16'(seen), 16'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 par_data", 16'(par_data), 16'h00);
      chk("R1 frame_pulse", 16'(fp), 16'h0);
      chk("R1 byte_clk", 16'(byte_clk), 16'h1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_no_arm();
      send_vec(64'(PAT), 48, 1'b0, "");
      send_vec(64'h77, 8, 1'b0, "");
      send_vec(64'h00, 8, 1'b1, "R2 no pulse without oof edge");
   endtask

   task automatic t_align();
      oof = 1'b1;
      send_vec(64'b101, 3, 1'b0, "");
      send_vec(64'(PAT), 48, 1'b0, "");
      send_vec(64'h5A, 8, 1'b0, "");
      chk("R3 first byte", 16'(par_data), 16'h5A);
      chk("R4 pulse with byte", 16'(fp), 16'h1);
      chk("R9 byte_clk high at byte", 16'(byte_clk), 16'h1);
      send_vec(64'hC, 4, 1'b0, "");
      chk("R9 byte_clk low mid byte", 16'(byte_clk), 16'h0);
      chk("R4 pulse still high", 16'(fp), 16'h1);
      send_vec(64'h3, 4, 1'b0, "");
      chk("R3 second byte", 16'(par_data), 16'hC3);
      chk("R4 pulse one byte", 16'(fp), 16'h0);
   endtask

   task automatic t_realign_then_oof_low();
      send_vec(64'b01101, 5, 1'b0, "");
      send_vec(64'(PAT), 48, 1'b0, "");
      send_vec(64'h3C, 8, 1'b0, "");
      chk("R5 realign byte", 16'(par_data), 16'h3C);
      chk("R5 realign pulse", 16'(fp), 16'h1);
      oof = 1'b0;
      send_vec(64'h11, 8, 1'b0, "");
      chk("R5 byte after oof low", 16'(par_data), 16'h11);
      send_vec({4'hA, PAT, 4'h7}, 56, 1'b1, "R8 no pulse when disarmed");
      chk("R8 phase kept", 16'(par_data), 16'h87);
   endtask

   task automatic t_oof_first();
      logic [55:0] v;
      v = {5'b10101, PAT, 3'b011};
      oof = 1'b1;
      send_vec(64'h00, 8, 1'b0, "");
      oof = 1'b0;
      send_vec(64'h00, 8, 1'b0, "");
      send_vec(64'b110, 3, 1'b0, "");
      send_vec(64'(PAT), 48, 1'b0, "");
      send_vec(64'h99, 8, 1'b0, "");
      chk("R6 still armed after oof fell", 16'(par_data), 16'h99);
      chk("R6 pulse", 16'(fp), 16'h1);
      send_vec(64'h42, 8, 1'b0, "");
      chk("R6 next byte", 16'(par_data), 16'h42);
      send_vec(64'(v), 56, 1'b1, "R6 disarmed after pulse");
      chk("R6 phase kept", 16'(par_data), 16'(v[7:0]));
   endtask

   task automatic t_squelch();
      sig_det = 1'b0;
      #1;
      chk("R7 squelch immediate", 16'(par_data), 16'h00);
      send_vec(64'hE7, 8, 1'b0, "");
      chk("R7 squelch held", 16'(par_data), 16'h00);
      sig_det = 1'b1;
      #1;
      chk("R7 byte restored", 16'(par_data), 16'hE7);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_no_arm();
      t_align();
      t_realign_then_oof_low();
      t_oof_first();
      t_squelch();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule